// File: doc/BRIEF.md
# Prescaled Watchdog Countdown Core

This block is a watchdog timer that runs on the reference clock. A prescaler divides that clock and produces ticks. A down-counter counts those ticks. When the counter expires, the block raises a one-cycle system reset request and sets a sticky expiry flag. Software keeps the system alive by restarting the countdown with a kick write before the counter runs out.

Four write strobes reach the core: prescale, reload, kick and on/off. Each strobe has already passed an unlock guard outside this block, so the core acts on any strobe it sees. All four share one write-data bus. The timeout is the prescale field plus one, multiplied by the reload value, in reference clock cycles. There is no data stream here, so the block has no valid/ready interface. Every pin is plain control or status, and no write can be stalled.

Top module: `wdog_countdown`

## Requirements
- R1: When the core runs with prescale field P and reload value N, `rst_req` goes high exactly (P+1)*N clock edges after the edge that enabled or restarted it. It stays high for one cycle only, unless (P+1)*N is 1.
- R2: The prescale field P takes any value from 0 to 0xFFFF and divides the clock by P+1. P = 0 gives one tick per cycle.
- R3: A reload write with a nonzero value in `wr_data[15:0]` stores that value and reloads the counter on the same edge. A reload write of 0 is ignored. The counter never shows 0.
- R4: A kick write with `wr_data` equal to 1 restarts both the prescaler and the counter. A kick write with any other value has no effect.
- R5: An on/off write enables the core when `wr_data[0]` is 1 and disables it when `wr_data[0]` is 0. Every on/off write restarts both stages. `running` shows the state.
- R6: While the core is disabled, `cur_count` equals `reload_val` and `rst_req` stays low.
- R7: `expired` goes high together with the first `rst_req` and stays high until `rst_n` is asserted.
- R8: After reset the core is disabled, the prescale field is 0, the reload value is 0xFFFF, `cur_count` is 0xFFFF, and `rst_req` and `expired` are low.
- R9: After an expiry the counter reloads and keeps running. The next `rst_req` follows another (P+1)*N edges later.
- R10: A prescale write stores the new value and restarts only the prescaler. `cur_count` is unchanged on that edge, and its next decrement comes P_new+1 edges later.
- R11: Any write strobe on an edge takes precedence over a tick on that edge. `rst_req` only follows an edge on which the counter showed 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 16 | Write data shared by all strobes |
| psc_wr | input | 1 | Prescale field write strobe (already unlocked) |
| reload_wr | input | 1 | Reload value write strobe (already unlocked) |
| kick_wr | input | 1 | Kick write strobe (already unlocked) |
| onoff_wr | input | 1 | On/off write strobe (already unlocked) |
| rst_req | output | 1 | One-cycle system reset request |
| expired | output | 1 | Sticky expiry flag |
| running | output | 1 | Core enabled |
| cur_count | output | 16 | Current down-counter value |
| psc_val | output | 16 | Stored prescale field |
| reload_val | output | 16 | Stored reload value |

## Verification
A prescaler that reloads one cycle late stretches every timeout by N cycles. The edge count from enable to `rst_req` exposes this on the first expiry. A counter that is not held while the core is off shows up on the next cycle, because `cur_count` then differs from `reload_val`. A kick or reload that is decoded wrongly moves the expiry edge away from the value computed from the write cycle, so the fault appears within a single period. A prescale write that also disturbs the counter changes `cur_count` on the write edge itself.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned KICK_CODE = 1;

  typedef struct packed {
    logic run;       // core enabled this cycle
    logic hold;      // core disabled after this edge
    logic pre_load;  // restart prescaler on this edge
    logic cnt_load;  // restart counter on this edge
  } wd_ctl_t;
endpackage

// File: rtl/wdog_cfg_regs.sv
module wdog_cfg_regs
  import wdog_pkg::*;
#(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16,
  parameter int WR_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             psc_wr,
  input  logic             reload_wr,
  input  logic             kick_wr,
  input  logic             onoff_wr,
  output logic [PSC_W-1:0] psc_q,
  output logic [CNT_W-1:0] rld_q,
  output logic [PSC_W-1:0] psc_nxt,
  output logic [CNT_W-1:0] rld_nxt,
  output wd_ctl_t          ctl
);
  localparam logic [CNT_W-1:0] RLD_RST = '1;

  logic run_q, run_nxt, rld_ok, kick_ok;

  assign rld_ok  = reload_wr && (wr_data[CNT_W-1:0] != '0);
  assign kick_ok = kick_wr && (wr_data == WR_W'(KICK_CODE));

  always_comb begin
    psc_nxt = psc_wr ? wr_data[PSC_W-1:0] : psc_q;
    rld_nxt = rld_ok ? wr_data[CNT_W-1:0] : rld_q;
    run_nxt = onoff_wr ? wr_data[0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      rld_q <= RLD_RST;
      run_q <= 1'b0;
    end else begin
      psc_q <= psc_nxt;
      rld_q <= rld_nxt;
      run_q <= run_nxt;
    end
  end

  always_comb begin
    ctl.run      = run_q;
    ctl.hold     = !run_nxt;
    ctl.cnt_load = rld_ok || kick_ok || onoff_wr;
    ctl.pre_load = ctl.cnt_load || psc_wr;
  end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wd_ctl_t          ctl,
  input  logic [PSC_W-1:0] psc_nxt,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt;

  assign tick = ctl.run && !ctl.pre_load && (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (ctl.hold || ctl.pre_load || pcnt == '0)
      pcnt <= psc_nxt;
    else
      pcnt <= pcnt - 1'b1;
  end
endmodule

// File: rtl/wdog_downcounter.sv
module wdog_downcounter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wd_ctl_t          ctl,
  input  logic             tick,
  input  logic [CNT_W-1:0] rld_nxt,
  output logic [CNT_W-1:0] cnt,
  output logic             fire,
  output logic             fired
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic last;
  assign last = tick && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '1;
      fire  <= 1'b0;
      fired <= 1'b0;
    end else begin
      fire <= last;
      if (last)
        fired <= 1'b1;
      if (ctl.hold || ctl.cnt_load || last)
        cnt <= rld_nxt;
      else if (tick)
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16,
  localparam int WR_W = (PSC_W > CNT_W) ? PSC_W : CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             psc_wr,
  input  logic             reload_wr,
  input  logic             kick_wr,
  input  logic             onoff_wr,
  output logic             rst_req,
  output logic             expired,
  output logic             running,
  output logic [CNT_W-1:0] cur_count,
  output logic [PSC_W-1:0] psc_val,
  output logic [CNT_W-1:0] reload_val
);
  wd_ctl_t          ctl;
  logic [PSC_W-1:0] psc_nxt;
  logic [CNT_W-1:0] rld_nxt;
  logic             tick;

  wdog_cfg_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W), .WR_W(WR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .psc_wr(psc_wr), .reload_wr(reload_wr), .kick_wr(kick_wr), .onoff_wr(onoff_wr),
    .psc_q(psc_val), .rld_q(reload_val), .psc_nxt(psc_nxt), .rld_nxt(rld_nxt),
    .ctl(ctl)
  );

  wdog_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .psc_nxt(psc_nxt), .tick(tick)
  );

  wdog_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .tick(tick), .rld_nxt(rld_nxt),
    .cnt(cur_count), .fire(rst_req), .fired(expired)
  );

  assign running = ctl.run;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             expired,
  input logic             running,
  input logic [CNT_W-1:0] cur_count,
  input logic [CNT_W-1:0] reload_val
);
  AST_REQ_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(cur_count) == CNT_W'(1)); // R11

  AST_REQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(running)); // R6

  AST_OFF_HOLDS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> cur_count == reload_val); // R6

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cur_count != '0); // R3

  AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> expired); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired); // R7
endmodule

bind wdog_countdown wdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .expired(expired),
  .running(running), .cur_count(cur_count), .reload_val(reload_val)
);

// File: tb/wdog_countdown_test.sv
module wdog_countdown_test;
  localparam int K_NONE = 0, K_PSC = 1, K_RLD = 2, K_KICK = 3, K_ONOFF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wr_data = '0;
  logic        psc_wr = 0, reload_wr = 0, kick_wr = 0, onoff_wr = 0;
  logic        rst_req, expired, running;
  logic [15:0] cur_count, psc_val, reload_val;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  wdog_countdown uut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .psc_wr(psc_wr),
    .reload_wr(reload_wr), .kick_wr(kick_wr), .onoff_wr(onoff_wr),
    .rst_req(rst_req), .expired(expired), .running(running),
    .cur_count(cur_count), .psc_val(psc_val), .reload_val(reload_val)
  );

  function automatic int period(input int p, input int n);
    return (p + 1) * n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_strobe(input int kind, input int val);
    wr_data   = 16'(val);
    psc_wr    = (kind == K_PSC);
    reload_wr = (kind == K_RLD);
    kick_wr   = (kind == K_KICK);
    onoff_wr  = (kind == K_ONOFF);
  endtask

  task automatic do_wr(input int kind, input int val);
    @(negedge clk);
    set_strobe(kind, val);
    @(posedge clk);
    #1 set_strobe(K_NONE, 0);
  endtask

  // Program P,N, enable, optionally write at edge 'at'; return edges to first
  // and second request and whether the request was low one edge after the first.
  task automatic measure(input int p, input int n, input int at, input int kind,
                         input int val, output int c1, output int c2, output bit pulse);
    int c;
    do_wr(K_ONOFF, 0);
    do_wr(K_PSC, p);
    do_wr(K_RLD, n);
    do_wr(K_ONOFF, 1);
    c1 = -1; c2 = -1; pulse = 1'b0; c = 0;
    while (c < 5000 && c2 < 0) begin
      c++;
      if (c == at) set_strobe(kind, val);
      @(posedge clk);
      #1 set_strobe(K_NONE, 0);
      if (c1 > 0 && c == c1 + 1) pulse = !rst_req;
      if (rst_req) begin
        if (c1 < 0) c1 = c;
        else c2 = c - c1;
      end
    end
    do_wr(K_ONOFF, 0);
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    int c1, c2, p, n, t, seen, old;
    bit pulse;
    void'($urandom(32'd7319));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(!running && !rst_req && !expired, "R8 flags", {running, rst_req, expired}, 0);
    check(psc_val == 16'h0, "R8 prescale", psc_val, 0);
    check(reload_val == 16'hFFFF && cur_count == 16'hFFFF, "R8 reload/count",
          cur_count, 16'hFFFF);

    // R2: divide by one, single-count period fires every edge
    measure(0, 1, 0, K_NONE, 0, c1, c2, pulse);
    check(c1 == 1 && c2 == 1, "R2 P=0 N=1 period", c1, 1);

    // R1 / R9: directed and random periods
    measure(2, 3, 0, K_NONE, 0, c1, c2, pulse);
    check(c1 == period(2, 3), "R1 directed period", c1, period(2, 3));
    for (int i = 0; i < 8; i++) begin
      p = int'($urandom % 6);
      n = 2 + int'($urandom % 24);
      t = period(p, n);
      measure(p, n, 0, K_NONE, 0, c1, c2, pulse);
      check(c1 == t, "R1 random period", c1, t);
      check(pulse, "R1 one-cycle request", !pulse, 0);
      check(c2 == t, "R9 second period", c2, t);
    end

    // R4: kick with 1 restarts, other values ignored
    measure(1, 10, 7, K_KICK, 1, c1, c2, pulse);
    check(c1 == 7 + period(1, 10), "R4 kick value 1", c1, 27);
    measure(1, 10, 7, K_KICK, 2, c1, c2, pulse);
    check(c1 == period(1, 10), "R4 kick value 2 ignored", c1, 20);
    measure(1, 10, 7, K_KICK, 0, c1, c2, pulse);
    check(c1 == period(1, 10), "R4 kick value 0 ignored", c1, 20);

    // R3: reload write mid-run reloads immediately
    measure(1, 10, 4, K_RLD, 5, c1, c2, pulse);
    check(c1 == 4 + period(1, 5), "R3 reload mid-run", c1, 14);

    // R11: on/off write coinciding with the expiry edge suppresses the request
    measure(0, 6, 6, K_ONOFF, 1, c1, c2, pulse);
    check(c1 == 12, "R11 write wins over tick", c1, 12);

    // R3: reload write of 0 ignored
    old = reload_val;
    do_wr(K_RLD, 0);
    #1;
    check(reload_val == 16'(old) && cur_count == 16'(old), "R3 zero reload ignored",
          reload_val, old);

    // R5 / R6: disabled core stays quiet
    check(!running, "R5 off after on/off write 0", running, 0);
    seen = 0;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk);
      #1;
      if (rst_req || cur_count != reload_val) seen++;
    end
    check(seen == 0, "R6 disabled hold", seen, 0);

    // R10: prescale write restarts only the prescaler
    do_wr(K_PSC, 3);
    do_wr(K_RLD, 50);
    do_wr(K_ONOFF, 1);
    check(running, "R5 on after on/off write 1", running, 1);
    repeat (2) @(posedge clk);
    #1 old = cur_count;
    do_wr(K_PSC, 5);
    check(cur_count == 16'(old) && psc_val == 16'd5, "R10 count kept on write",
          cur_count, old);
    c1 = 0;
    while (cur_count == 16'(old) && c1 < 100) begin
      @(posedge clk);
      #1 c1++;
    end
    check(c1 == 6 && cur_count == 16'(old - 1), "R10 next decrement", c1, 6);
    do_wr(K_ONOFF, 0);

    // R7: flag remains after disable and clears only with reset
    repeat (5) @(posedge clk);
    #1 check(expired, "R7 sticky flag", expired, 1);
    rst_n = 1'b0;
    #1 check(!expired, "R7 cleared by reset", expired, 0);
    @(negedge clk) rst_n = 1'b1;
    finish_up();
  end
endmodule